// File: doc/BRIEF.md
# Power-Fault Operating Mode Sequencer

This block chooses the chip's operating mode. It takes a reset input, the output of a system-power-good comparator and a battery-present flag. It times the wake-up after reset and the PLL settling after power returns, counting real-time-clock, crystal and oscillator tick strobes. It then moves the chip between reset, mission, brownout, sleep and LCD modes.

When power is lost, the battery flag decides where the block goes. With a battery it enters brownout and keeps wake high. Without one it drops wake and sleeps. On recovery from brownout the configuration is kept and the processor gets an interrupt. On recovery from sleep or LCD mode the block instead pulses a configuration-clear strobe. The watchdog enable follows mission mode. The comparator, the oscillators, the processor and the configuration storage are outside the block.

Top module: `pwr_mode_seq`

## Requirements
- R1: From the first clock edge at which `hold_rst_i` is sampled high, and for as long as it stays high, the outputs are: `mode_o`=0 (reset), `wake_o`=0, `pll_ok_o`=0, `wdog_en_o`=0. `cfg_clr_o` is 1 in every cycle that `hold_rst_i` is high.
- R2: `hold_rst_i` may fall while `pwr_good_i` is 1. In that case `mode_o` stays 0 until `WAKE_TICKS` (default 4100) `rtc_tick_i` strobes have been counted. On the following edge the outputs become `mode_o`=1 (mission), `wake_o`=1 and `pll_ok_o`=1.
- R3: `hold_rst_i` may fall while `pwr_good_i` is 0. In that case `rtc_tick_i` is ignored and `mode_o` stays 0 until `SHORT_TICKS` (default 2) `xtal_tick_i` strobes have been counted. On the following edge the outputs become `mode_o`=2 (brownout), `wake_o`=1 and `pll_ok_o`=0.
- R4: `pll_ok_o` goes low in the same cycle that `pwr_good_i` goes low, with no clock edge in between.
- R5: In mission mode, a sampled `pwr_good_i`=0 moves the block on the next edge. With `bat_ok_i`=1 it goes to `mode_o`=2 with `wake_o`=1. With `bat_ok_i`=0 it goes to `mode_o`=3 (sleep) with `wake_o`=0.
- R6: In brownout, sleep or LCD mode, once `pwr_good_i` is 1 the block counts `PLL_TICKS` (default 4100) `osc_tick_i` strobes. During this count the mode is unchanged and `pll_ok_o`=0. On the edge after the count completes, `mode_o` becomes 1 and `pll_ok_o` becomes 1.
- R7: If `pwr_good_i` drops before the PLL count completes, the count restarts from zero.
- R8: Brownout to mission raises `irq_o` for exactly the first mission cycle. `cfg_clr_o` stays 0 during this transition.
- R9: Sleep or LCD to mission raises `cfg_clr_o` for exactly the first mission cycle. `irq_o` stays 0 during this transition.
- R10: In brownout, `lcd_req_i`=1 moves the block on the next edge to `mode_o`=4 (LCD) with `wake_o`=0. In mission mode `lcd_req_i` has no effect on `mode_o`.
- R11: `wdog_en_o` is 1 exactly when `mode_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| hold_rst_i | input | 1 | External reset request, active high |
| pwr_good_i | input | 1 | System-power comparator output |
| bat_ok_i | input | 1 | Battery present flag |
| rtc_tick_i | input | 1 | Real-time-clock tick strobe |
| xtal_tick_i | input | 1 | Crystal-clock tick strobe |
| osc_tick_i | input | 1 | Oscillator tick strobe for PLL settling |
| lcd_req_i | input | 1 | Software request to enter LCD mode from brownout |
| mode_o | output | 3 | Mode code: 0 reset, 1 mission, 2 brownout, 3 sleep, 4 LCD |
| wake_o | output | 1 | Wake signal |
| pll_ok_o | output | 1 | PLL-ready flag |
| irq_o | output | 1 | Brownout-recovery interrupt pulse |
| cfg_clr_o | output | 1 | Configuration clear |
| wdog_en_o | output | 1 | Watchdog enable |

## Verification
The reset release is tried with power present and with power absent. This shows that the tick source and the count length are chosen from the power state. The case without power also feeds it real-time-clock strobes, which must not advance it. Power loss is applied with and without a battery, and recovery is run from brownout, sleep and LCD mode. These separate the interrupt path from the configuration-clear path. A power dip partway through the PLL count shows whether the count restarts or resumes. Counts ending one tick short of the limit confirm that the timers are exact.

// File: rtl/pms_pkg.sv
package pms_pkg;
  typedef enum logic [2:0] {
    ST_HOLD,
    ST_BOOT,
    ST_MISSION,
    ST_BROWN,
    ST_SLEEP,
    ST_LCD
  } pms_state_e;

  localparam logic [2:0] MODE_RESET   = 3'd0;
  localparam logic [2:0] MODE_MISSION = 3'd1;
  localparam logic [2:0] MODE_BROWN   = 3'd2;
  localparam logic [2:0] MODE_SLEEP   = 3'd3;
  localparam logic [2:0] MODE_LCD     = 3'd4;

  function automatic logic [2:0] mode_of(pms_state_e s);
    case (s)
      ST_MISSION: return MODE_MISSION;
      ST_BROWN:   return MODE_BROWN;
      ST_SLEEP:   return MODE_SLEEP;
      ST_LCD:     return MODE_LCD;
      default:    return MODE_RESET;
    endcase
  endfunction

  function automatic logic is_low_power(pms_state_e s);
    return (s == ST_BROWN) || (s == ST_SLEEP) || (s == ST_LCD);
  endfunction
endpackage

// File: rtl/pms_tick_timer.sv
module pms_tick_timer #(
  parameter int CNT_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (clr_i)                      cnt_q <= '0;
    else if (tick_i && cnt_q != limit_i) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == limit_i);

  // R7: once expired, only a clear restarts the count
  a_r7_done_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !clr_i && $stable(limit_i)) |=> done_o);
  a_r7_clear_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && limit_i != '0) |=> !done_o);
endmodule

// File: rtl/pms_mode_fsm.sv
module pms_mode_fsm
  import pms_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hold_rst_i,
  input  logic       pwr_good_i,
  input  logic       bat_ok_i,
  input  logic       lcd_req_i,
  input  logic       boot_done_i,
  input  logic       pll_done_i,
  output pms_state_e state_o,
  output logic       boot_short_o,
  output logic       irq_o,
  output logic       clr_pulse_o
);
  pms_state_e state_q, state_d;
  logic       short_q;
  logic       irq_q, clr_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_HOLD:    state_d = ST_BOOT;
      ST_BOOT:    if (boot_done_i) state_d = short_q ? ST_BROWN : ST_MISSION;
      ST_MISSION: if (!pwr_good_i) state_d = bat_ok_i ? ST_BROWN : ST_SLEEP;
      ST_BROWN: begin
        if (pll_done_i)     state_d = ST_MISSION;
        else if (lcd_req_i) state_d = ST_LCD;
      end
      ST_SLEEP, ST_LCD: if (pll_done_i) state_d = ST_MISSION;
      default:    state_d = ST_HOLD;
    endcase
    if (hold_rst_i) state_d = ST_HOLD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HOLD;
      short_q <= 1'b0;
      irq_q   <= 1'b0;
      clr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_HOLD) short_q <= !pwr_good_i;
      irq_q <= (state_q == ST_BROWN) && (state_d == ST_MISSION);
      clr_q <= ((state_q == ST_SLEEP) || (state_q == ST_LCD)) && (state_d == ST_MISSION);
    end
  end

  assign state_o      = state_q;
  assign boot_short_o = short_q;
  assign irq_o        = irq_q;
  assign clr_pulse_o  = clr_q;

  a_r8_irq_from_brown: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> (state_q == ST_MISSION && $past(state_q) == ST_BROWN));
  a_r8_irq_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |=> !irq_q);
  a_r9_clr_from_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_q |-> ($past(state_q) == ST_SLEEP || $past(state_q) == ST_LCD));
  a_r9_clr_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_q |=> !clr_q);
  a_r5_no_battery_sleeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_MISSION && !pwr_good_i && !bat_ok_i && !hold_rst_i) |=> state_q == ST_SLEEP);
  a_r3_short_boot_brown: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BROWN && $past(state_q) == ST_BOOT) |-> $past(short_q));
  a_r1_hold_forces_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_rst_i |=> state_q == ST_HOLD);
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pms_pkg::*;
#(
  parameter int WAKE_TICKS  = 4100,
  parameter int SHORT_TICKS = 2,
  parameter int PLL_TICKS   = 4100
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hold_rst_i,
  input  logic       pwr_good_i,
  input  logic       bat_ok_i,
  input  logic       rtc_tick_i,
  input  logic       xtal_tick_i,
  input  logic       osc_tick_i,
  input  logic       lcd_req_i,
  output logic [2:0] mode_o,
  output logic       wake_o,
  output logic       pll_ok_o,
  output logic       irq_o,
  output logic       cfg_clr_o,
  output logic       wdog_en_o
);
  localparam int MAX_T  = (WAKE_TICKS > PLL_TICKS) ? WAKE_TICKS : PLL_TICKS;
  localparam int MAX_A  = (MAX_T > SHORT_TICKS) ? MAX_T : SHORT_TICKS;
  localparam int CNT_W  = $clog2(MAX_A + 1);
  localparam int N_TMR  = 2;
  localparam int T_BOOT = 0;
  localparam int T_PLL  = 1;

  pms_state_e state;
  logic       boot_short, clr_pulse;
  logic [N_TMR-1:0] t_clr, t_tick, t_done;
  logic [CNT_W-1:0] t_limit [N_TMR];

  assign t_clr[T_BOOT]   = (state != ST_BOOT);
  assign t_tick[T_BOOT]  = boot_short ? xtal_tick_i : rtc_tick_i;
  assign t_limit[T_BOOT] = boot_short ? CNT_W'(SHORT_TICKS) : CNT_W'(WAKE_TICKS);
  assign t_clr[T_PLL]    = !(is_low_power(state) && pwr_good_i);
  assign t_tick[T_PLL]   = osc_tick_i;
  assign t_limit[T_PLL]  = CNT_W'(PLL_TICKS);

  for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
    pms_tick_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (t_clr[g]),
      .tick_i (t_tick[g]),
      .limit_i(t_limit[g]),
      .done_o (t_done[g])
    );
  end

  pms_mode_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hold_rst_i  (hold_rst_i),
    .pwr_good_i  (pwr_good_i),
    .bat_ok_i    (bat_ok_i),
    .lcd_req_i   (lcd_req_i),
    .boot_done_i (t_done[T_BOOT]),
    .pll_done_i  (t_done[T_PLL]),
    .state_o     (state),
    .boot_short_o(boot_short),
    .irq_o       (irq_o),
    .clr_pulse_o (clr_pulse)
  );

  assign mode_o    = mode_of(state);
  assign wake_o    = (state == ST_MISSION) || (state == ST_BROWN);
  // comparator fall kills PLL-ready without waiting for an edge
  assign pll_ok_o  = (state == ST_MISSION) && pwr_good_i;
  assign cfg_clr_o = hold_rst_i || clr_pulse;
  assign wdog_en_o = (state == ST_MISSION);

  a_r6_pll_low_until_mission: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_low_power(state) && !t_done[T_PLL]) |=> (mode_o != MODE_MISSION || $past(hold_rst_i) == 1'b0) && !($past(is_low_power(state)) && pll_ok_o && !$past(t_done[T_PLL])));
  a_r11_wdog_mission: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wdog_en_o) |-> ($past(state) == ST_BOOT || $past(t_done[T_PLL])));
  a_r10_lcd_wake_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_BROWN && lcd_req_i && !t_done[T_PLL] && !hold_rst_i) |=> (mode_o == MODE_LCD && !wake_o));
endmodule

// File: tb/sim_pwr_mode_seq.sv
`timescale 1ns/1ps
module sim_pwr_mode_seq;
  localparam int WT = 4100;
  localparam int ST = 2;
  localparam int PT = 4100;

  logic clk = 0, rst_n = 0;
  logic hold = 1, pwr = 1, bat = 1, rtc = 0, xtal = 0, osc = 0, lcd = 0;
  logic [2:0] mode;
  logic wake, pll, irq, clr, wdog;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pwr_mode_seq #(.WAKE_TICKS(WT), .SHORT_TICKS(ST), .PLL_TICKS(PT)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .hold_rst_i(hold), .pwr_good_i(pwr), .bat_ok_i(bat),
    .rtc_tick_i(rtc), .xtal_tick_i(xtal), .osc_tick_i(osc), .lcd_req_i(lcd),
    .mode_o(mode), .wake_o(wake), .pll_ok_o(pll), .irq_o(irq), .cfg_clr_o(clr), .wdog_en_o(wdog)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // sel: 0 rtc, 1 xtal, 2 osc; tick held high for n edges
  task automatic ticks(input int sel, input int n);
    if (n == 0) return;
    case (sel) 0: rtc = 1; 1: xtal = 1; default: osc = 1; endcase
    repeat (n) @(negedge clk);
    rtc = 0; xtal = 0; osc = 0;
  endtask

  task automatic t_reset();
    hold = 1; pwr = 1;
    idle(2);
    chk("R1 mode", mode, 0); chk("R1 wake", wake, 0);
    chk("R1 pll", pll, 0);   chk("R1 wdog", wdog, 0);
    chk("R1 cfg_clr", clr, 1);
  endtask

  task automatic t_boot_long();
    hold = 0; idle(2);
    ticks(0, WT - 1); idle(2);
    chk("R2 mode before limit", mode, 0);
    chk("R2 wake before limit", wake, 0);
    ticks(0, 1); idle(1);
    chk("R2 mode", mode, 1); chk("R2 wake", wake, 1); chk("R2 pll", pll, 1);
    chk("R11 wdog in mission", wdog, 1);
    chk("R9 no clr on boot", clr, 0);
  endtask

  task automatic t_lcd_ignored();
    lcd = 1; idle(2); lcd = 0;
    chk("R10 lcd ignored in mission", mode, 1);
  endtask

  task automatic t_loss_battery();
    bat = 1; pwr = 0; #1;
    chk("R4 pll falls at once", pll, 0);
    idle(1);
    chk("R5 brownout mode", mode, 2); chk("R5 brownout wake", wake, 1);
    chk("R11 wdog off", wdog, 0);
  endtask

  task automatic t_restore_brown();
    pwr = 1; ticks(2, 3000);
    pwr = 0; idle(1); pwr = 1;
    ticks(2, PT - 1); idle(2);
    chk("R7 restart after dip", mode, 2);
    chk("R6 pll low while counting", pll, 0);
    ticks(2, 1); idle(1);
    chk("R6 mission", mode, 1); chk("R6 pll", pll, 1);
    chk("R8 irq", irq, 1); chk("R8 cfg kept", clr, 0);
    idle(1);
    chk("R8 irq one cycle", irq, 0);
  endtask

  task automatic t_sleep_restore();
    bat = 0; pwr = 0; idle(1);
    chk("R5 sleep mode", mode, 3); chk("R5 sleep wake", wake, 0);
    bat = 1; pwr = 1;
    ticks(2, PT); idle(1);
    chk("R9 mission from sleep", mode, 1);
    chk("R9 cfg_clr", clr, 1); chk("R9 no irq", irq, 0);
    idle(1);
    chk("R9 cfg_clr one cycle", clr, 0);
  endtask

  task automatic t_lcd_restore();
    pwr = 0; idle(1);
    lcd = 1; idle(1); lcd = 0;
    chk("R10 lcd mode", mode, 4); chk("R10 lcd wake", wake, 0);
    pwr = 1; ticks(2, PT); idle(1);
    chk("R9 mission from lcd", mode, 1); chk("R9 cfg_clr lcd", clr, 1);
    chk("R11 wdog", wdog, 1);
  endtask

  task automatic t_boot_short();
    hold = 1; pwr = 0; idle(2);
    chk("R1 mode again", mode, 0); chk("R1 cfg_clr again", clr, 1);
    hold = 0; idle(2);
    ticks(0, 10); idle(2);
    chk("R3 rtc ignored", mode, 0);
    ticks(1, ST - 1); idle(2);
    chk("R3 before limit", mode, 0);
    ticks(1, 1); idle(1);
    chk("R3 brownout", mode, 2); chk("R3 wake", wake, 1); chk("R3 pll", pll, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_boot_long();
    t_lcd_ignored();
    t_loss_battery();
    t_restore_brown();
    t_sleep_restore();
    t_lcd_restore();
    t_boot_short();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule